// File: doc/BRIEF.md
# Cascaded Interrupt Cause Controller

This block gathers 96 level-sensitive interrupt sources into three 32-bit groups: a low main group, a high main group and a group of general-purpose pins. Every group has a latched cause word and a mask word. The pin group does not reach the CPU directly. Its masked causes are reduced into four summary bits that sit in the high main cause word. The high mask must enable those summary bits before a pin interrupt can go any further.

Software reaches the block over a plain 32-bit register bus. The bus has a write strobe, a window select (main registers or pin registers), a byte offset, write data and combinational read data. A select-cause register serves as a fast dispatch read. It returns whichever main half has work pending, and one flag bit tells which half it is.

A single CPU interrupt line is driven by a two-state machine. The state `IRQ_IDLE` moves to `IRQ_RAISED` on any clock edge where some cause is set under its mask. `IRQ_RAISED` returns to `IRQ_IDLE` on the first edge where no such cause remains. The output is high exactly in `IRQ_RAISED`.

Top module: `cascade_intc`

## Requirements
- R1: After reset every cause word is zero, the low mask and pin mask are zero, the high mask is 0x0F000000, and the CPU interrupt is low.
- R2: A cause bit is set on each clock edge where its source is high, whatever the mask. It stays set after the source drops until software clears it.
- R3: A write to a cause register clears each bit written as 0 and leaves each bit written as 1. A source that is still high sets its bit again on the same edge, so a write of zero clears every bit whose source is low.
- R4: In the pin window (window select = 1), offset 0x08 is the pin cause and offset 0x0C is the pin mask.
- R5: In the main window (window select = 0), the offsets are 0x04 low cause, 0x0C high cause, 0x14 low mask, 0x1C high mask and 0x24 select-cause. Select-cause is read-only.
- R6: High cause bits 24..27 are summaries. Bit 24+g is set when any pin cause bit in pins 8g..8g+7 is set and enabled by the pin mask. The high source inputs on bits 24..27 and writes to those cause bits have no effect.
- R7: Select-cause returns the high cause word with bit 30 forced to 1 whenever (high cause AND high mask) is nonzero. Otherwise it returns the low cause word with bit 30 forced to 0.
- R8: The CPU interrupt is high in the cycle after an edge where (low cause AND low mask) or (high cause AND high mask) is nonzero, and low in the cycle after an edge where both are zero.
- R9: Reads of any other offset in either window return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_win | input | 1 | Window select: 0 main, 1 pin |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| src_lo | input | 32 | Low main group sources |
| src_hi | input | 32 | High main group sources (bits 24..27 unused) |
| pin_src | input | 32 | Pin group sources |
| cpu_irq | output | 1 | CPU interrupt output |

## Verification
The bench goes after these corner cases:
- A clear written while the source is still high. A design that clears unconditionally would lose a live level interrupt.
- A pin cause that sits under its pin mask. It must reach the high word only through its group's summary bit. A design with the wrong group slice or the wrong bit order would light the wrong summary bit, or a bit that is masked.
- Select-cause when both halves are pending. If high priority were dropped, or bit 30 were not forced, software would dispatch from the wrong group.
- Writes to unmapped offsets and to the summary bit positions. A loose decoder would corrupt a mask or a cause.
- The timing of the interrupt, one cycle after the masked cause appears. A design that is off by one cycle would be seen by the comparison made on every clock.

// File: rtl/cascade_intc_pkg.sv
package cascade_intc_pkg;
    localparam int OFF_LO_CAUSE = 'h04;
    localparam int OFF_HI_CAUSE = 'h0C;
    localparam int OFF_LO_MASK  = 'h14;
    localparam int OFF_HI_MASK  = 'h1C;
    localparam int OFF_SELECT   = 'h24;
    localparam int OFF_PIN_CAUSE = 'h08;
    localparam int OFF_PIN_MASK  = 'h0C;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/intc_cause_bank.sv
module intc_cause_bank #(
    parameter int W = 32,
    parameter logic [W-1:0] HOLD_ZERO = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] cause
);
    logic [W-1:0] kept;

    always_comb begin
        kept = clr_wr ? (cause & clr_data) : cause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause <= '0;
        else        cause <= (kept | src) & ~HOLD_ZERO;
    end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mask <= RST_VAL;
        else if (wr) mask <= wdata;
    end
endmodule

// File: rtl/intc_pin_summary.sv
module intc_pin_summary #(
    parameter int W = 32,
    parameter int GROUPS = 4
) (
    input  logic [W-1:0]      cause,
    input  logic [W-1:0]      mask,
    output logic [GROUPS-1:0] summary
);
    localparam int GW = W / GROUPS;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign summary[g] = |(cause[g*GW +: GW] & mask[g*GW +: GW]);
    end
endmodule

// File: rtl/intc_irq_fsm.sv
module intc_irq_fsm
    import cascade_intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    output logic irq
);
    irq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_IDLE:   if (pend)  state_nx = IRQ_RAISED;
            IRQ_RAISED: if (!pend) state_nx = IRQ_IDLE;
            default:    state_nx = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        irq = (state == IRQ_RAISED);
    end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
    import cascade_intc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int SUM_LSB    = 24,
    parameter int SUM_GROUPS = 4,
    parameter int SEL_FLAG   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] src_lo,
    input  logic [DATA_W-1:0] src_hi,
    input  logic [DATA_W-1:0] pin_src,
    output logic              cpu_irq
);
    localparam int TOP_PAD = DATA_W - SUM_LSB - SUM_GROUPS;
    localparam logic [DATA_W-1:0] SUM_FIELD =
        {{TOP_PAD{1'b0}}, {SUM_GROUPS{1'b1}}, {SUM_LSB{1'b0}}};
    localparam logic [DATA_W-1:0] FLAG_BIT = DATA_W'(1) << SEL_FLAG;

    logic main_wr, pin_wr;
    logic wr_lo_cause, wr_hi_cause, wr_lo_mask, wr_hi_mask;
    logic wr_pin_cause, wr_pin_mask;
    logic [DATA_W-1:0] lo_cause, hi_lat, pin_cause;
    logic [DATA_W-1:0] lo_mask, hi_mask, pin_mask;
    logic [SUM_GROUPS-1:0] pin_sum;
    logic [DATA_W-1:0] hi_word, sel_word;
    logic pend_lo, pend_hi, irq_pend;

    assign main_wr      = bus_wr && !bus_win;
    assign pin_wr       = bus_wr &&  bus_win;
    assign wr_lo_cause  = main_wr && (bus_addr == ADDR_W'(OFF_LO_CAUSE));
    assign wr_hi_cause  = main_wr && (bus_addr == ADDR_W'(OFF_HI_CAUSE));
    assign wr_lo_mask   = main_wr && (bus_addr == ADDR_W'(OFF_LO_MASK));
    assign wr_hi_mask   = main_wr && (bus_addr == ADDR_W'(OFF_HI_MASK));
    assign wr_pin_cause = pin_wr  && (bus_addr == ADDR_W'(OFF_PIN_CAUSE));
    assign wr_pin_mask  = pin_wr  && (bus_addr == ADDR_W'(OFF_PIN_MASK));

    intc_cause_bank #(.W(DATA_W)) u_lo_cause (
        .clk(clk), .rst_n(rst_n), .src(src_lo),
        .clr_wr(wr_lo_cause), .clr_data(bus_wdata), .cause(lo_cause));

    intc_cause_bank #(.W(DATA_W), .HOLD_ZERO(SUM_FIELD)) u_hi_cause (
        .clk(clk), .rst_n(rst_n), .src(src_hi),
        .clr_wr(wr_hi_cause), .clr_data(bus_wdata), .cause(hi_lat));

    intc_cause_bank #(.W(DATA_W)) u_pin_cause (
        .clk(clk), .rst_n(rst_n), .src(pin_src),
        .clr_wr(wr_pin_cause), .clr_data(bus_wdata), .cause(pin_cause));

    intc_mask_reg #(.W(DATA_W)) u_lo_mask (
        .clk(clk), .rst_n(rst_n), .wr(wr_lo_mask), .wdata(bus_wdata), .mask(lo_mask));

    intc_mask_reg #(.W(DATA_W), .RST_VAL(SUM_FIELD)) u_hi_mask (
        .clk(clk), .rst_n(rst_n), .wr(wr_hi_mask), .wdata(bus_wdata), .mask(hi_mask));

    intc_mask_reg #(.W(DATA_W)) u_pin_mask (
        .clk(clk), .rst_n(rst_n), .wr(wr_pin_mask), .wdata(bus_wdata), .mask(pin_mask));

    intc_pin_summary #(.W(DATA_W), .GROUPS(SUM_GROUPS)) u_sum (
        .cause(pin_cause), .mask(pin_mask), .summary(pin_sum));

    assign hi_word  = hi_lat | {{TOP_PAD{1'b0}}, pin_sum, {SUM_LSB{1'b0}}};
    assign pend_lo  = |(lo_cause & lo_mask);
    assign pend_hi  = |(hi_word & hi_mask);
    assign irq_pend = pend_lo || pend_hi;
    assign sel_word = pend_hi ? (hi_word | FLAG_BIT) : (lo_cause & ~FLAG_BIT);

    always_comb begin
        bus_rdata = '0;
        if (!bus_win) begin
            unique case (bus_addr)
                ADDR_W'(OFF_LO_CAUSE): bus_rdata = lo_cause;
                ADDR_W'(OFF_HI_CAUSE): bus_rdata = hi_word;
                ADDR_W'(OFF_LO_MASK):  bus_rdata = lo_mask;
                ADDR_W'(OFF_HI_MASK):  bus_rdata = hi_mask;
                ADDR_W'(OFF_SELECT):   bus_rdata = sel_word;
                default:               bus_rdata = '0;
            endcase
        end else begin
            unique case (bus_addr)
                ADDR_W'(OFF_PIN_CAUSE): bus_rdata = pin_cause;
                ADDR_W'(OFF_PIN_MASK):  bus_rdata = pin_mask;
                default:                bus_rdata = '0;
            endcase
        end
    end

    intc_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pend(irq_pend), .irq(cpu_irq));
endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int SEL_FLAG = 30,
    parameter logic [DATA_W-1:0] SUM_FIELD = 32'h0F00_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_win,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] src_lo,
    input logic [DATA_W-1:0] lo_cause,
    input logic [DATA_W-1:0] lo_mask,
    input logic [DATA_W-1:0] hi_mask,
    input logic [DATA_W-1:0] hi_word,
    input logic [DATA_W-1:0] pin_cause,
    input logic [DATA_W-1:0] pin_mask,
    input logic              pend_hi,
    input logic              irq_pend,
    input logic              cpu_irq
);
    logic rd_sel, rd_mapped;
    assign rd_sel = !bus_win && (bus_addr == ADDR_W'('h24));
    assign rd_mapped = bus_win ? (bus_addr == ADDR_W'('h08) || bus_addr == ADDR_W'('h0C))
                               : (bus_addr == ADDR_W'('h04) || bus_addr == ADDR_W'('h0C) ||
                                  bus_addr == ADDR_W'('h14) || bus_addr == ADDR_W'('h1C) ||
                                  bus_addr == ADDR_W'('h24));

    // R1
    mask_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (hi_mask == SUM_FIELD && lo_mask == '0 && pin_mask == '0));

    // R2
    level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((lo_cause & $past(src_lo)) == $past(src_lo)));

    // R6
    summary_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_word & SUM_FIELD) != '0) |-> ((pin_cause & pin_mask) != '0));

    // R7
    sel_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> (bus_rdata[SEL_FLAG] == pend_hi));

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cpu_irq == $past(irq_pend)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mapped |-> (bus_rdata == '0));
endmodule

bind cascade_intc cascade_intc_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_FLAG(SEL_FLAG), .SUM_FIELD(SUM_FIELD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .src_lo(src_lo), .lo_cause(lo_cause), .lo_mask(lo_mask),
    .hi_mask(hi_mask), .hi_word(hi_word), .pin_cause(pin_cause), .pin_mask(pin_mask),
    .pend_hi(pend_hi), .irq_pend(irq_pend), .cpu_irq(cpu_irq));

// File: tb/cascade_intc_tb.sv
module cascade_intc_tb;
    localparam logic [31:0] SUMF = 32'h0F00_0000;
    localparam logic [31:0] FLAG = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_win = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_lo = '0, src_hi = '0, pin_src = '0;
    logic        cpu_irq;

    int checks = 0, errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    logic [31:0] m_lo = '0, m_hi = '0, m_pin = '0;
    logic [31:0] m_lom = '0, m_him = SUMF, m_pinm = '0;
    logic        m_irq = 1'b0;

    always #4 clk = ~clk;

    cascade_intc u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_win(bus_win),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_lo(src_lo), .src_hi(src_hi), .pin_src(pin_src), .cpu_irq(cpu_irq));

    function automatic logic [31:0] hiword();
        logic [31:0] w = m_hi;
        for (int g = 0; g < 4; g++)
            if ((m_pin[g*8 +: 8] & m_pinm[g*8 +: 8]) != 8'h00) w[24+g] = 1'b1;
        return w;
    endfunction

    function automatic logic [31:0] mread(logic win, logic [7:0] a);
        logic [31:0] hw = hiword();
        if (!win) begin
            if (a == 8'h04) return m_lo;
            if (a == 8'h0C) return hw;
            if (a == 8'h14) return m_lom;
            if (a == 8'h1C) return m_him;
            if (a == 8'h24) return ((hw & m_him) != 0) ? (hw | FLAG) : (m_lo & ~FLAG);
            return 32'h0;
        end
        if (a == 8'h08) return m_pin;
        if (a == 8'h0C) return m_pinm;
        return 32'h0;
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        logic [31:0] nlo, nhi, npin, nlom, nhim, npinm;
        logic nirq;
        if (!rst_n) begin
            nlo = 0; nhi = 0; npin = 0; nlom = 0; nhim = SUMF; npinm = 0; nirq = 0;
        end else begin
            nlo = m_lo; nhi = m_hi; npin = m_pin;
            nlom = m_lom; nhim = m_him; npinm = m_pinm;
            nirq = ((m_lo & m_lom) != 0) || ((hiword() & m_him) != 0);
            if (bus_wr && !bus_win) begin
                if (bus_addr == 8'h04) nlo = m_lo & bus_wdata;
                if (bus_addr == 8'h0C) nhi = m_hi & bus_wdata;
                if (bus_addr == 8'h14) nlom = bus_wdata;
                if (bus_addr == 8'h1C) nhim = bus_wdata;
            end
            if (bus_wr && bus_win) begin
                if (bus_addr == 8'h08) npin = m_pin & bus_wdata;
                if (bus_addr == 8'h0C) npinm = bus_wdata;
            end
            nlo = nlo | src_lo;
            nhi = (nhi | src_hi) & ~SUMF;
            npin = npin | pin_src;
        end
        @(posedge clk);
        m_lo = nlo; m_hi = nhi; m_pin = npin;
        m_lom = nlom; m_him = nhim; m_pinm = npinm; m_irq = nirq;
        #1;
        chk({31'b0, cpu_irq}, {31'b0, m_irq}, {cur_tag, " irq R8"});
        chk(bus_rdata, mread(bus_win, bus_addr), {cur_tag, " rdata"});
    endtask

    task automatic wr(logic win, logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_win = win; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic win, logic [7:0] a);
        bus_win = win; bus_addr = a;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0] offs [8];
        offs = '{8'h04, 8'h08, 8'h0C, 8'h14, 8'h1C, 8'h24, 8'h30, 8'h00};
        repeat (3) tick();
        rst_n = 1'b1;
        cur_tag = "R1";
        rd(0, 8'h1C); chk(bus_rdata, SUMF, "R1 hi mask");
        rd(0, 8'h14); rd(1, 8'h0C); rd(0, 8'h04);
        chk({31'b0, cpu_irq}, 32'h0, "R1 irq");

        cur_tag = "R2";
        src_lo = 32'h8; tick(); src_lo = 0;
        rd(0, 8'h04); chk(bus_rdata, 32'h8, "R2 latched while masked");

        cur_tag = "R8";
        wr(0, 8'h14, 32'h8); tick(); tick();
        chk({31'b0, cpu_irq}, 32'h1, "R8 irq raised");

        cur_tag = "R3";
        src_lo = 32'h10; wr(0, 8'h04, 32'h0); src_lo = 0;
        rd(0, 8'h04); chk(bus_rdata, 32'h10, "R3 live source survives clear");
        wr(0, 8'h04, 32'hFFFF_FFEF);
        rd(0, 8'h04); chk(bus_rdata, 32'h0, "R3 write-zero bit cleared");

        cur_tag = "R7";
        src_hi = 32'h0000_0101; tick(); src_hi = 0;
        wr(0, 8'h1C, 32'h0F00_0001);
        rd(0, 8'h24); chk(bus_rdata, 32'h4000_0101, "R7 high half flagged");

        cur_tag = "R6";
        pin_src = 32'h0000_0300; tick(); pin_src = 0;
        src_hi = SUMF; tick(); src_hi = 0;
        wr(1, 8'h0C, 32'h0000_0100);
        rd(0, 8'h0C); chk(bus_rdata, 32'h0200_0101, "R6 group1 summary");

        cur_tag = "R4";
        wr(1, 8'h08, ~32'h0000_0100);
        rd(1, 8'h08); chk(bus_rdata, 32'h0000_0200, "R4 pin cause clear");
        rd(0, 8'h0C); chk(bus_rdata, 32'h0000_0101, "R6 masked pin gives no summary");

        cur_tag = "R9";
        wr(0, 8'h30, 32'hFFFF_FFFF); wr(1, 8'h04, 32'hFFFF_FFFF); wr(0, 8'h24, 32'h0);
        rd(0, 8'h30); chk(bus_rdata, 32'h0, "R9 unmapped read");
        rd(1, 8'h14); chk(bus_rdata, 32'h0, "R9 pin window unmapped");
        rd(0, 8'h1C); chk(bus_rdata, 32'h0F00_0001, "R9 hi mask untouched");

        cur_tag = "R5";
        wr(0, 8'h1C, 32'h0);
        src_lo = 32'h4000_0004; tick(); src_lo = 0;
        rd(0, 8'h24); chk(bus_rdata, 32'h0000_0004, "R7 low half, flag clear");
        rd(0, 8'h04); chk(bus_rdata, 32'h4000_0004, "R5 low cause offset");

        cur_tag = "R2/R3/R6/R7/R8 sweep";
        r = 32'hACE1_2345;
        for (int i = 0; i < 600; i++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            bus_wr = r[0] & r[1];
            bus_win = r[2];
            bus_addr = offs[r[6:4]];
            bus_wdata = {r[15:0], r[31:16]};
            src_lo  = (r[9:7] == 3'b0) ? (32'h1 << r[14:10]) : 32'h0;
            src_hi  = (r[17:15] == 3'b0) ? (32'h1 << r[22:18]) : 32'h0;
            pin_src = (r[25:23] == 3'b0) ? (32'h1 << r[30:26]) : 32'h0;
            tick();
        end
        bus_wr = 0; src_lo = 0; src_hi = 0; pin_src = 0;
        tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule